// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a host processor. It tracks three 8-bit sets: requests waiting to be acknowledged, lines that were acknowledged and still wait for end-of-interrupt (in-service), and lines that software has blocked (mask). Each line can capture on a rising edge or follow its level. Priority is either fixed or rotating.

Software programs the block through a small register-write port. That port sets the mask, the per-line trigger mode, the vector base and the priority mode, and it issues end-of-interrupt commands. The host answers a raised interrupt with a one-cycle acknowledge pulse. One cycle later the block returns an 8-bit vector with a valid strobe. An acknowledge that arrives while the output is low returns the vector of the lowest line as a spurious interrupt and marks nothing as in-service. All inputs are assumed to be synchronous to `clk`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset (synchronous, active-low) clears all requests and in-service bits, masks every line, selects edge capture on all lines with fixed priority, and sets the vector base to 0. After reset `int_o`=0, `vec_vld_o`=0 and `vec_o`=0.
- R2: A line in edge mode (bit i of the trigger register = 0) records a request on a 0-to-1 change of its input. The request stays recorded when the input falls, until that line is acknowledged.
- R3: A line in level mode (bit i of the trigger register = 1) has a request exactly while its input is high. Nothing is latched: if the input falls before the acknowledge, the request is gone.
- R4: A line whose mask bit is 1 never raises `int_o`, but its recorded request is kept. Clearing the mask bit later raises `int_o`.
- R5: In fixed priority, line 0 is highest and line 7 is lowest.
- R6: When `ack_i` is high in a cycle where `int_o` is high, the winning line's request is cleared and its in-service bit is set at that clock edge. In the next cycle `vec_vld_o`=1 and `vec_o` = {base[4:0], line[2:0]}. `vec_vld_o` is 1 only in the cycle after an `ack_i` cycle.
- R7: `int_o` is 1 only when the highest-priority unmasked request is strictly higher in priority than the highest-priority in-service line. A request on a line of equal or lower priority does not raise it.
- R8: An acknowledge while `int_o` is 0 returns `vec_o` = {base, 3'd7} with `vec_vld_o`=1, and sets no in-service bit.
- R9: A non-specific end-of-interrupt (command register, data[7:6]=2'b01) clears only the highest-priority in-service bit.
- R10: A specific end-of-interrupt (data[7:6]=2'b10, line number in data[2:0]) clears only that line's in-service bit.
- R11: In rotating mode (data[7:6]=2'b00 with data[0]=1), a line becomes lowest priority when its end-of-interrupt is taken, and the lines after it follow in ascending order, wrapping around. Any priority-mode write restarts the order with line 0 highest.
- R12: Register map at `wr_addr_i`: 0 = mask (bit i masks line i); 1 = vector base in data[7:3] (data[2:0] are ignored); 2 = trigger mode (bit i = 1 selects level mode); 3 = command. Command op 2'b11 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Interrupt request lines, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select for a write |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | Single-cycle acknowledge from the host |
| int_o | output | 1 | Interrupt to the host |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_vld_o | output | 1 | High in the cycle after an acknowledge |

## Verification
A wrong in-service set shows up at `int_o`. A leftover bit holds back a request that should win, and a missing bit lets a nested request of equal or lower priority through. Either shows in the first cycle after the offending acknowledge or end-of-interrupt. The bench therefore raises requests of known relative priority after each acknowledge and each end-of-interrupt, and reads `int_o` one cycle later. A wrong rotation pointer or request register shows in the vector of the next acknowledge. Each scenario ends with such an acknowledge, so the vector is read one cycle after the pulse.

// File: rtl/pic_pkg.sv
// Package: shared constants and encodings for the priority interrupt controller.
// Assumes an 8-line configuration; the register-select and command-op codes
// below are the contract with software.
package pic_pkg;

    localparam int NLINES = 8;
    localparam int BASEW  = 5;

    // Register select on the write port
    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_BASE = 2'd1,
        REG_TRIG = 2'd2,
        REG_CMD  = 2'd3
    } reg_sel_e;

    // Command operation, taken from the top two data bits
    typedef enum logic [1:0] {
        OP_PRIO_MODE = 2'b00,
        OP_EOI_ANY   = 2'b01,
        OP_EOI_LINE  = 2'b10,
        OP_RESERVED  = 2'b11
    } cmd_op_e;

endpackage

// File: rtl/pic_prio_resolve.sv
// Module: pic_prio_resolve
// Finds the highest-priority set bit of a request vector for a circular
// priority order. The line after low_id_i is the highest; low_id_i itself is
// the lowest. Rank 0 is the highest. Purely combinational.
// Assumes N is a power of two.
module pic_prio_resolve #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] low_id_i,
    output logic          any_o,
    output logic [IW-1:0] id_o,
    output logic [IW-1:0] rank_o
);

    // Scan from the lowest rank to the highest so the best-ranked set bit wins
    always_comb begin
        any_o  = 1'b0;
        id_o   = '0;
        rank_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [IW-1:0] idx;
            idx = low_id_i + IW'(k + 1);
            if (vec_i[idx]) begin
                any_o  = 1'b1;
                id_o   = idx;
                rank_o = IW'(k);
            end
        end
    end

endmodule

// File: rtl/pic_req_capture.sv
// Module: pic_req_capture
// Builds the request register from the raw lines. Edge-mode lines latch a
// rising edge until cleared by an acknowledge. Level-mode lines pass the input
// level through unlatched. Assumes irq_i is synchronous to clk. The previous
// sample is loaded during reset, so lines already high at reset are not edges.
module pic_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] req_o
);

    logic [N-1:0] irq_q;
    logic [N-1:0] edge_q;
    logic [N-1:0] rise;

    // Detect low-to-high changes against the previous sample
    always_comb rise = irq_i & ~irq_q;

    // Keep the previous input sample for edge detection
    always_ff @(posedge clk) begin
        irq_q <= irq_i;
    end

    // Latch edges, drop acknowledged lines, and hold nothing for level lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= ((edge_q & ~clr_i) | rise) & ~lvl_i;
        end
    end

    // Choose the request source per line
    always_comb req_o = (lvl_i & irq_i) | (~lvl_i & edge_q);

    // A latched edge request survives a falling input until acknowledged
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_q) & ~$past(clr_i) & ~$past(lvl_i) & ~lvl_i & ~edge_q) == '0)); // R2

    // Level-mode lines never keep a latched bit
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_q & $past(lvl_i)) == '0)); // R3

endmodule

// File: rtl/pic_service.sv
// Module: pic_service
// Holds the in-service register and the rotating lowest-priority pointer.
// Sets an in-service bit on a granted acknowledge and clears bits on
// non-specific or specific end-of-interrupt. In rotating mode the line whose
// end-of-interrupt is taken becomes the lowest priority. A mode write restarts
// the pointer at N-1, which gives line 0 the highest priority.
module pic_service #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_i,
    input  logic [IW-1:0] grant_id_i,
    input  logic          eoi_any_i,
    input  logic          eoi_line_i,
    input  logic [IW-1:0] eoi_id_i,
    input  logic          rot_i,
    input  logic          mode_wr_i,
    input  logic          top_any_i,
    input  logic [IW-1:0] top_id_i,
    output logic [N-1:0]  isr_o,
    output logic [IW-1:0] low_id_o
);

    logic [N-1:0]  isr_q;
    logic [IW-1:0] low_q;
    logic [N-1:0]  set_vec;
    logic [N-1:0]  clr_vec;
    logic          rot_move;
    logic [IW-1:0] rot_id;

    // Decode the bit set by a grant
    always_comb begin
        set_vec = '0;
        if (grant_i) set_vec[grant_id_i] = 1'b1;
    end

    // Decode the bit cleared by an end-of-interrupt and the rotation target
    always_comb begin
        clr_vec  = '0;
        rot_move = 1'b0;
        rot_id   = eoi_id_i;
        if (eoi_any_i && top_any_i) begin
            clr_vec[top_id_i] = 1'b1;
            rot_move          = 1'b1;
            rot_id            = top_id_i;
        end else if (eoi_line_i) begin
            clr_vec[eoi_id_i] = 1'b1;
            rot_move          = 1'b1;
        end
    end

    // Update the in-service register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q | set_vec) & ~clr_vec;
        end
    end

    // Track the lowest-priority line for rotating mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= IW'(N - 1);
        end else if (mode_wr_i) begin
            low_q <= IW'(N - 1);
        end else if (rot_i && rot_move) begin
            low_q <= rot_id;
        end
    end

    assign isr_o    = isr_q;
    assign low_id_o = low_q;

    // In-service bits appear only through a granted acknowledge
    AST_ISR_SET_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_i |=> ((isr_q & ~$past(isr_q)) == '0)); // R6

    // An end-of-interrupt clears at most one in-service bit
    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_any_i || eoi_line_i) |=> ($countones($past(isr_q) & ~isr_q) <= 1)); // R9

    // Without an end-of-interrupt, no in-service bit is dropped
    AST_ISR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(eoi_any_i || eoi_line_i) |=> (($past(isr_q) & ~isr_q) == '0)); // R10

    // The priority order only moves on an end-of-interrupt or a mode write
    AST_ROT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(eoi_any_i || eoi_line_i || mode_wr_i) |=> $stable(low_q)); // R11

    // In fixed mode the order never leaves line 0 highest
    AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_i && !mode_wr_i && (low_q == IW'(N - 1))) |=> (low_q == IW'(N - 1))); // R5

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Eight-line priority interrupt controller. Holds the software-visible
// configuration (mask, trigger mode, vector base, priority mode) written over
// a simple write port. It resolves the pending and in-service priorities,
// drives the interrupt output, and returns a vector one cycle after each
// acknowledge pulse. Assumes all inputs are synchronous to clk and ack_i is a
// single-cycle pulse.
module prio_irq_ctrl #(
    parameter int N_LINES = pic_pkg::NLINES,
    parameter int BASE_W  = pic_pkg::BASEW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES-1:0]         irq_i,
    input  logic                       wr_en_i,
    input  logic [1:0]                 wr_addr_i,
    input  logic [N_LINES-1:0]         wr_data_i,
    input  logic                       ack_i,
    output logic                       int_o,
    output logic [BASE_W+$clog2(N_LINES)-1:0] vec_o,
    output logic                       vec_vld_o
);

    import pic_pkg::*;

    localparam int IW   = $clog2(N_LINES);
    localparam int VECW = BASE_W + IW;

    // Configuration state
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] trig_q;
    logic [BASE_W-1:0]  base_q;
    logic               rot_q;

    // Decoded write-port actions
    reg_sel_e sel;
    cmd_op_e  op;
    logic     cmd_wr;
    logic     mode_wr;
    logic     eoi_any;
    logic     eoi_line;

    // Datapath between the submodules
    logic [N_LINES-1:0] req_vec;
    logic [N_LINES-1:0] pend_vec;
    logic [N_LINES-1:0] isr_vec;
    logic [N_LINES-1:0] ack_clr;
    logic [IW-1:0]      low_id;
    logic               pend_any;
    logic [IW-1:0]      pend_id;
    logic [IW-1:0]      pend_rank;
    logic               isr_any;
    logic [IW-1:0]      isr_id;
    logic [IW-1:0]      isr_rank;
    logic               grant;
    logic [VECW-1:0]    vec_q;
    logic               vld_q;

    // Split the write port into register select and command op
    always_comb begin
        sel      = reg_sel_e'(wr_addr_i);
        op       = cmd_op_e'(wr_data_i[N_LINES-1 -: 2]);
        cmd_wr   = wr_en_i && (sel == REG_CMD);
        mode_wr  = cmd_wr && (op == OP_PRIO_MODE);
        eoi_any  = cmd_wr && (op == OP_EOI_ANY);
        eoi_line = cmd_wr && (op == OP_EOI_LINE);
    end

    // Hold the mask, trigger, base and priority-mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            trig_q <= '0;
            base_q <= '0;
            rot_q  <= 1'b0;
        end else if (wr_en_i) begin
            case (sel)
                REG_MASK: mask_q <= wr_data_i;
                REG_BASE: base_q <= wr_data_i[N_LINES-1 -: BASE_W];
                REG_TRIG: trig_q <= wr_data_i;
                default:  if (op == OP_PRIO_MODE) rot_q <= wr_data_i[0];
            endcase
        end
    end

    pic_req_capture #(.N(N_LINES)) req_cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (irq_i),
        .lvl_i (trig_q),
        .clr_i (ack_clr),
        .req_o (req_vec)
    );

    // Only unmasked requests compete for the output
    always_comb pend_vec = req_vec & ~mask_q;

    pic_prio_resolve #(.N(N_LINES), .IW(IW)) pend_res_i (
        .vec_i    (pend_vec),
        .low_id_i (low_id),
        .any_o    (pend_any),
        .id_o     (pend_id),
        .rank_o   (pend_rank)
    );

    pic_prio_resolve #(.N(N_LINES), .IW(IW)) isr_res_i (
        .vec_i    (isr_vec),
        .low_id_i (low_id),
        .any_o    (isr_any),
        .id_o     (isr_id),
        .rank_o   (isr_rank)
    );

    // Raise the output only when the best request outranks the best in-service line
    always_comb int_o = pend_any && (!isr_any || (pend_rank < isr_rank));

    // A granted acknowledge clears the winning request
    always_comb begin
        grant   = ack_i && int_o;
        ack_clr = '0;
        if (grant) ack_clr[pend_id] = 1'b1;
    end

    pic_service #(.N(N_LINES), .IW(IW)) svc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_i    (grant),
        .grant_id_i (pend_id),
        .eoi_any_i  (eoi_any),
        .eoi_line_i (eoi_line),
        .eoi_id_i   (wr_data_i[IW-1:0]),
        .rot_i      (rot_q),
        .mode_wr_i  (mode_wr),
        .top_any_i  (isr_any),
        .top_id_i   (isr_id),
        .isr_o      (isr_vec),
        .low_id_o   (low_id)
    );

    // Register the vector returned to the host, spurious lines use the last id
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= ack_i;
            if (ack_i) vec_q <= {base_q, grant ? pend_id : IW'(N_LINES - 1)};
        end
    end

    assign vec_o     = vec_q;
    assign vec_vld_o = vld_q;

    // The output never rises for masked lines alone
    AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((req_vec & ~mask_q) != '0)); // R4

    // A line already in service never raises the output again
    AST_INT_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> !isr_vec[pend_id]); // R7

    // An acknowledge with the output low returns the last line's vector
    AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o) |=> (vec_vld_o && (vec_o[IW-1:0] == IW'(N_LINES - 1)))); // R8

    // The valid strobe follows an acknowledge only
    AST_VLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_vld_o); // R6

    // The vector base field tracks the base register at the acknowledge
    AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (vec_o[VECW-1:IW] == $past(base_q))); // R12

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
// Directed bench for prio_irq_ctrl: one task per scenario, each with its own checks.
module prio_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       ack;
    logic       int_o;
    logic [7:0] vec_o;
    logic       vec_vld_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .ack_i     (ack),
        .int_o     (int_o),
        .vec_o     (vec_o),
        .vec_vld_o (vec_vld_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
    endtask

    task automatic do_ack(output logic [7:0] v, output logic vl);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        v  = vec_o;
        vl = vec_vld_o;
    endtask

    // R1 reset state, everything masked, default base and edge capture
    task automatic t_reset();
        logic [7:0] v; logic vl;
        do_reset();
        chk("R1 int_o after reset", int_o, 0);
        chk("R1 vec_vld_o after reset", vec_vld_o, 0);
        chk("R1 vec_o after reset", vec_o, 0);
        set_irq(8'hFF);
        chk("R1 all lines masked", int_o, 0);
        wr(2'd0, 8'hBF);
        chk("R1 unmask line 6 raises", int_o, 1);
        do_ack(v, vl);
        chk("R1 base zero vector", v, 8'h06);
        chk("R1 valid strobe", vl, 1);
    endtask

    // R2 edge latch held after input falls; R6 vector and clear on ack
    task automatic t_edge();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hA8);
        set_irq(8'h10);
        chk("R2 edge raises int", int_o, 1);
        set_irq(8'h00);
        chk("R2 request held after fall", int_o, 1);
        do_ack(v, vl);
        chk("R6 vector base|line", v, 8'hAC);
        chk("R6 valid", vl, 1);
        chk("R6 request cleared by ack", int_o, 0);
        @(negedge clk);
        chk("R6 valid is one cycle", vec_vld_o, 0);
    endtask

    // R4 masked request kept and raised once unmasked
    task automatic t_mask();
        do_reset();
        set_irq(8'h04);
        set_irq(8'h00);
        chk("R4 masked line quiet", int_o, 0);
        wr(2'd0, 8'hFB);
        chk("R4 unmask reveals kept request", int_o, 1);
        wr(2'd0, 8'hFF);
        chk("R4 remask hides request", int_o, 0);
    endtask

    // R3 level mode follows input; R7 equal priority blocked by in-service
    task automatic t_level();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h00);
        set_irq(8'h02);
        chk("R3 level high raises", int_o, 1);
        set_irq(8'h00);
        chk("R3 level low drops", int_o, 0);
        set_irq(8'h02);
        do_ack(v, vl);
        chk("R3 level vector", v, 8'h01);
        chk("R7 same line in service blocks", int_o, 0);
        wr(2'd3, 8'h40);
        chk("R3 level still high after EOI", int_o, 1);
    endtask

    // R5 fixed priority, R7 nesting, R9 non-specific EOI
    task automatic t_nest();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd0, 8'h00);
        set_irq(8'h28);
        do_ack(v, vl);
        chk("R5 line 3 beats line 5", v, 8'h03);
        chk("R7 lower request blocked", int_o, 0);
        set_irq(8'h2A);
        chk("R7 higher request nests", int_o, 1);
        do_ack(v, vl);
        chk("R5 line 1 vector", v, 8'h01);
        chk("R7 line 5 still blocked", int_o, 0);
        wr(2'd3, 8'h40);
        chk("R9 first EOI clears line 1 only", int_o, 0);
        wr(2'd3, 8'h40);
        chk("R9 second EOI clears line 3", int_o, 1);
        do_ack(v, vl);
        chk("R9 line 5 served", v, 8'h05);
    endtask

    // R10 specific EOI touches only its line
    task automatic t_spec_eoi();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd0, 8'h00);
        set_irq(8'h03);
        do_ack(v, vl);
        chk("R10 line 0 served", v, 8'h00);
        chk("R10 line 1 blocked", int_o, 0);
        wr(2'd3, 8'h85);
        chk("R10 EOI of idle line no effect", int_o, 0);
        wr(2'd3, 8'h80);
        chk("R10 EOI of line 0 releases", int_o, 1);
    endtask

    // R8 spurious vector, no in-service bit; R12 base low bits ignored
    task automatic t_spurious();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd0, 8'h00);
        do_ack(v, vl);
        chk("R8 spurious vector", v, 8'h07);
        chk("R8 spurious valid", vl, 1);
        wr(2'd1, 8'h45);
        do_ack(v, vl);
        chk("R12 base low bits ignored", v, 8'h47);
        set_irq(8'h80);
        chk("R8 no in-service set by spurious", int_o, 1);
    endtask

    // R11 rotating priority after non-specific and specific EOI
    task automatic t_rotate();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h01);
        set_irq(8'h05);
        do_ack(v, vl);
        chk("R11 initial order line 0 first", v, 8'h00);
        wr(2'd3, 8'h40);
        chk("R11 line 2 raises after EOI", int_o, 1);
        set_irq(8'h04);
        set_irq(8'h05);
        do_ack(v, vl);
        chk("R11 line 0 now lowest", v, 8'h02);
        chk("R11 line 0 blocked by line 2", int_o, 0);
        wr(2'd3, 8'h82);
        chk("R11 specific EOI releases", int_o, 1);
        do_ack(v, vl);
        chk("R11 line 0 served", v, 8'h00);
    endtask

    // R12 reserved command op has no effect
    task automatic t_reserved();
        logic [7:0] v; logic vl;
        do_reset();
        wr(2'd0, 8'h00);
        set_irq(8'h08);
        do_ack(v, vl);
        chk("R12 line 3 served", v, 8'h03);
        set_irq(8'h28);
        chk("R12 line 5 blocked", int_o, 0);
        wr(2'd3, 8'hC0);
        chk("R12 reserved op ignored", int_o, 0);
        wr(2'd3, 8'h40);
        chk("R12 EOI after reserved", int_o, 1);
    endtask

    initial begin
        t_reset();
        t_edge();
        t_mask();
        t_level();
        t_nest();
        t_spec_eoi();
        t_spurious();
        t_rotate();
        t_reserved();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule